// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter watches the byte stream of an arriving Ethernet frame and decides, from the six destination-address bytes at its head, whether the frame is for this station. Three tests are available: a broadcast rule, a 64-entry multicast hash table indexed by part of a CRC-32 of the destination, and an exact comparison against a programmed station address. Broadcast is tested first, the hash path second, the exact comparison last. A promiscuous override lets every frame through while still reporting whether the address matched.

The CRC is built serially, one byte per clock, as the destination arrives. The decision is registered. A one-cycle done pulse marks it, and the accept and miss flags then hold until the next start-of-frame byte. Configuration comes in on plain input pins and is sampled on the byte that completes the decision.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, accept_o, miss_o and done_o are all 0.
- R2: A destination of six 0xFF bytes is broadcast. It is a miss exactly when bcast_rej_i is 1. This test takes priority over the hash path, even though byte 0 has bit 0 set.
- R3: A non-broadcast destination whose byte 0 has bit 0 set uses the hash path. The CRC starts at all ones. Each byte is fed LSB first: feedback = crc[31] xor bit, crc shifts left one place, and it is xored with 0x04C11DB7 when feedback is 1. The index is crc[31:26] after the sixth byte. Indices 0 to 31 select hash_lo_i[index] and indices 32 to 63 select hash_hi_i[index-32]. A 0 bit is a miss. On this path the exact-match comparison has no effect.
- R4: With hash_all_i = 1, a non-broadcast destination with byte 0 bit 0 clear also uses the hash path of R3. An exact station match then does not prevent a miss.
- R5: Otherwise, destination bytes 0 to 5 are compared with stn_hi_i[15:8], stn_hi_i[7:0], stn_lo_i[31:24], stn_lo_i[23:16], stn_lo_i[15:8] and stn_lo_i[7:0]. Any mismatched byte is a miss.
- R6: A frame whose eof_i byte arrives before six destination bytes have been taken is a miss, whatever its contents.
- R7: accept_o is 1 when the frame is not a miss or when promisc_i is 1. Under promiscuous mode miss_o still reports the miss.
- R8: done_o is high for exactly one cycle, the cycle after the deciding byte (the sixth byte, or an earlier eof_i byte). Bytes after the sixth produce no further decision. A new sof_i byte restarts address collection.
- R9: accept_o and miss_o hold their value until the next byte with sof_i. That byte clears both to 0, unless it also decides a one-byte frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | byte_i carries a frame byte this cycle |
| sof_i | input | 1 | The current byte is the first of a frame |
| eof_i | input | 1 | The current byte is the last of a frame |
| byte_i | input | 8 | Frame byte |
| stn_hi_i | input | 16 | Station address bytes 0 and 1 |
| stn_lo_i | input | 32 | Station address bytes 2 to 5 |
| hash_lo_i | input | 32 | Hash table bits for indices 0 to 31 |
| hash_hi_i | input | 32 | Hash table bits for indices 32 to 63 |
| bcast_rej_i | input | 1 | Broadcast destinations count as a miss |
| hash_all_i | input | 1 | Send unicast destinations through the hash path |
| promisc_i | input | 1 | Accept every frame |
| done_o | output | 1 | One-cycle pulse: a decision is available |
| accept_o | output | 1 | The frame is accepted |
| miss_o | output | 1 | The destination did not match |

## Verification
The bench goes after the priority order first. Broadcast frames are sent with an empty hash table, and multicast frames whose exact station match would pass. A filter that checked the group bit before broadcast, or that fell back to the exact compare, would give the wrong flags for these frames. A sweep of multicast addresses programs only the one hash bit each address should select, and then every bit except that one. This exposes a wrong CRC bit order, a wrong index slice, or swapped table halves. Frames of one to five bytes, frames longer than six, and a start marker that arrives in the middle of a frame check that the decision is taken once and from the right bytes. Idle stretches and a fresh start marker check that the flags hold and then clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int          DA_BYTES = 6;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  // one byte, LSB first, non-reflected register
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ b[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_da_cnt.sv
module rxf_da_cnt #(
  parameter int NB = 6,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          sof_i,
  input  logic          eof_i,
  output logic          take_o,
  output logic [CW-1:0] idx_o,
  output logic          last_o,
  output logic          short_o
);
  logic          active_q;
  logic [CW-1:0] cnt_q;

  assign idx_o   = sof_i ? '0 : cnt_q;
  assign take_o  = vld_i & (sof_i | active_q);
  assign last_o  = take_o & (idx_o == CW'(NB - 1));
  assign short_o = take_o & eof_i & ~last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (take_o) begin
      cnt_q    <= idx_o + CW'(1);
      active_q <= ~last_o & ~eof_i;
    end
  end
endmodule

// File: rtl/rxf_crc.sv
module rxf_crc
  import rxf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        take_i,
  input  logic        sof_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;
  logic [31:0] cur;

  assign cur   = sof_i ? CRC_INIT : crc_q;
  assign crc_o = crc_step(cur, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (take_i) crc_q <= crc_o;
  end
endmodule

// File: rtl/rxf_da_cmp.sv
module rxf_da_cmp #(
  parameter int NB = 6,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          sof_i,
  input  logic [CW-1:0] idx_i,
  input  logic [7:0]    byte_i,
  input  logic [8*NB-1:0] stn_i,
  output logic          bcast_o,
  output logic          ucast_o,
  output logic          group_o
);
  logic [7:0] stn_b [NB];
  logic [7:0] exp_b;
  logic       bc_q, uc_q, grp_q;
  logic       bc_cur, uc_cur;

  for (genvar g = 0; g < NB; g++) begin : g_stn
    assign stn_b[g] = stn_i[8*(NB-1-g) +: 8];
  end

  always_comb begin
    exp_b = '0;
    for (int k = 0; k < NB; k++)
      if (idx_i == CW'(k)) exp_b = stn_b[k];
  end

  assign bc_cur  = sof_i | bc_q;
  assign uc_cur  = sof_i | uc_q;
  assign bcast_o = bc_cur & (byte_i == 8'hFF);
  assign ucast_o = uc_cur & (byte_i == exp_b);
  assign group_o = sof_i ? byte_i[0] : grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bc_q  <= 1'b0;
      uc_q  <= 1'b0;
      grp_q <= 1'b0;
    end else if (take_i) begin
      bc_q  <= bcast_o;
      uc_q  <= ucast_o;
      grp_q <= group_o;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int HASH_IW = 6,
  localparam int NB     = DA_BYTES,
  localparam int CW     = $clog2(NB + 1),
  localparam int HALF_W = 2 ** (HASH_IW - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [7:0]        byte_i,
  input  logic [15:0]       stn_hi_i,
  input  logic [31:0]       stn_lo_i,
  input  logic [HALF_W-1:0] hash_lo_i,
  input  logic [HALF_W-1:0] hash_hi_i,
  input  logic              bcast_rej_i,
  input  logic              hash_all_i,
  input  logic              promisc_i,
  output logic              done_o,
  output logic              accept_o,
  output logic              miss_o
);
  logic          take, last, short_f;
  logic [CW-1:0] idx;
  logic [31:0]   crc_n;
  logic          bc_n, uc_n, grp_n;
  logic [2*HALF_W-1:0] hash_tbl;
  logic [HASH_IW-1:0]  hash_idx;
  logic          hash_hit, addr_miss, decide, dec_miss;
  logic          done_q, acc_q, miss_q;

  rxf_da_cnt #(.NB(NB)) u_cnt (
    .clk_i, .rst_ni,
    .vld_i(byte_vld_i), .sof_i, .eof_i,
    .take_o(take), .idx_o(idx), .last_o(last), .short_o(short_f)
  );

  rxf_crc u_crc (
    .clk_i, .rst_ni,
    .take_i(take), .sof_i, .byte_i, .crc_o(crc_n)
  );

  rxf_da_cmp #(.NB(NB)) u_cmp (
    .clk_i, .rst_ni,
    .take_i(take), .sof_i, .idx_i(idx), .byte_i,
    .stn_i({stn_hi_i, stn_lo_i}),
    .bcast_o(bc_n), .ucast_o(uc_n), .group_o(grp_n)
  );

  assign hash_tbl = {hash_hi_i, hash_lo_i};
  assign hash_idx = crc_n[31 -: HASH_IW];
  assign hash_hit = hash_tbl[hash_idx];

  // priority: broadcast, then hash path, then exact match
  always_comb begin
    if (bc_n)                    addr_miss = bcast_rej_i;
    else if (grp_n | hash_all_i) addr_miss = ~hash_hit;
    else                         addr_miss = ~uc_n;
  end

  assign decide   = last | short_f;
  assign dec_miss = short_f | addr_miss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      acc_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      done_q <= decide;
      if (decide) begin
        miss_q <= dec_miss;
        acc_q  <= ~dec_miss | promisc_i;
      end else if (byte_vld_i && sof_i) begin
        miss_q <= 1'b0;
        acc_q  <= 1'b0;
      end
    end
  end

  assign done_o   = done_q;
  assign accept_o = acc_q;
  assign miss_o   = miss_q;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_vld_i,
  input logic sof_i,
  input logic eof_i,
  input logic promisc_i,
  input logic done_o,
  input logic accept_o,
  input logic miss_o
);
  a_r7_hit_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !miss_o |-> accept_o);

  a_r7_promisc_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && miss_o |-> accept_o == $past(promisc_i));

  a_r6_one_byte_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && sof_i && eof_i |=> done_o && miss_o);

  a_r8_done_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(byte_vld_i));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && !$past(byte_vld_i && sof_i) |-> $stable(accept_o) && $stable(miss_o));

  a_r9_sof_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && sof_i && !eof_i |=> !accept_o && !miss_o && !done_o);
endmodule

bind rx_addr_filter rxf_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i), .sof_i(sof_i),
  .eof_i(eof_i), .promisc_i(promisc_i), .done_o(done_o),
  .accept_o(accept_o), .miss_o(miss_o)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [47:0] STN  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC   = 48'h01_00_5E_00_00_01;

  typedef struct packed {
    logic [47:0] da;
    logic [47:0] stn;
    logic [1:0]  hm;   // 0 empty, 1 only selected bit, 2 all but selected bit
    logic        bcr;
    logic        hall;
    logic        prom;
    logic        exp_miss;
    logic        exp_acc;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{STN,                  STN, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 hit
    '{48'h02_11_22_33_44_56, STN, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 last byte
    '{48'h06_11_22_33_44_55, STN, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 first byte
    '{48'h02_11_22_33_44_56, STN, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 promisc
    '{BC,                   STN, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 priority
    '{BC,                   STN, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 reject
    '{BC,                   STN, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 R7
    '{MC,                   STN, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 hit
    '{MC,                   STN, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 miss
    '{MC,                   STN, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 R7
    '{STN,                  STN, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 forced
    '{48'h02_AA_BB_CC_DD_EE, STN, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 hit
    '{MC,                   MC,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}  // R3 exact ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0]  bt = '0;
  logic [47:0] stn = '0;
  logic [31:0] hlo = '0, hhi = '0;
  logic        bcr = 1'b0, hall = 1'b0, prom = 1'b0;
  logic        done, acc, miss;

  int checks = 0;
  int errors = 0;
  int dec_cnt = 0;
  logic dec_acc = 1'b0, dec_miss = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_addr_filter u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .sof_i(sof), .eof_i(eof),
    .byte_i(bt), .stn_hi_i(stn[47:32]), .stn_lo_i(stn[31:0]),
    .hash_lo_i(hlo), .hash_hi_i(hhi), .bcast_rej_i(bcr), .hash_all_i(hall),
    .promisc_i(prom), .done_o(done), .accept_o(acc), .miss_o(miss)
  );

  always @(negedge clk) begin
    if (done) begin
      dec_cnt  = dec_cnt + 1;
      dec_acc  = acc;
      dec_miss = miss;
    end
  end

  function automatic logic [5:0] bench_idx(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic b;
      b = da[40 - 8*(n/8) + (n%8)];
      c = (c << 1) ^ (((c[31] ^ b) == 1'b1) ? POLY : 32'h0);
    end
    return c[31:26];
  endfunction

  task automatic set_hash(input logic [47:0] da, input logic [1:0] hm);
    logic [63:0] t;
    t = 64'd0;
    if (hm != 2'd0) t[bench_idx(da)] = 1'b1;
    if (hm == 2'd2) t = ~t;
    hlo = t[31:0];
    hhi = t[63:32];
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] da, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      vld = 1'b1;
      sof = (i == 0);
      eof = (i == len - 1);
      bt  = (i < 6) ? da[47 - 8*i -: 8] : (8'hA5 ^ 8'(i));
    end
    @(negedge clk);
    vld = 1'b0; sof = 1'b0; eof = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame_expect(input logic [47:0] da, input int len,
                              input logic em, input logic ea, input string tag);
    int d0;
    d0 = dec_cnt;
    send(da, len);
    check(dec_cnt - d0 == 1, {tag, " decision count"}, dec_cnt - d0, 1);
    check(dec_miss == em, {tag, " miss"}, int'(dec_miss), int'(em));
    check(dec_acc == ea, {tag, " accept"}, int'(dec_acc), int'(ea));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({done, acc, miss} == 3'b000, "R1 reset outputs", int'({done, acc, miss}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({done, acc, miss} == 3'b000, "R1 after release", int'({done, acc, miss}), 0);

    for (int v = 0; v < NV; v++) begin
      stn = VEC[v].stn; bcr = VEC[v].bcr; hall = VEC[v].hall; prom = VEC[v].prom;
      set_hash(VEC[v].da, VEC[v].hm);
      frame_expect(VEC[v].da, 8, VEC[v].exp_miss, VEC[v].exp_acc,
                   $sformatf("R2-R7 vector %0d", v));
    end

    // R3 hash sweep over both table halves
    stn = STN; bcr = 1'b0; hall = 1'b0; prom = 1'b0;
    for (int k = 0; k < 16; k++) begin
      logic [47:0] da;
      da = {40'h01_00_5E_00_00, 8'(k * 17)};
      set_hash(da, 2'd1);
      frame_expect(da, 6, 1'b0, 1'b1, $sformatf("R3 sweep hit idx %0d", bench_idx(da)));
      set_hash(da, 2'd2);
      frame_expect(da, 6, 1'b1, 1'b0, $sformatf("R3 sweep miss idx %0d", bench_idx(da)));
    end

    // R6 short frames, broadcast content
    hlo = '1; hhi = '1;
    for (int l = 1; l < 6; l++)
      frame_expect(BC, l, 1'b1, 1'b0, $sformatf("R6 short len %0d", l));
    prom = 1'b1;
    frame_expect(STN, 3, 1'b1, 1'b1, "R6 R7 short promisc");
    prom = 1'b0;

    // R8 long frame: one decision, tail ignored
    frame_expect(STN, 20, 1'b0, 1'b1, "R8 long frame");

    // R9 hold across idle cycles
    repeat (6) @(negedge clk);
    check(acc == 1'b1 && miss == 1'b0 && done == 1'b0, "R9 hold",
          int'({done, acc, miss}), 3'b010);

    // R9 sof byte clears, then R8 decision from restarted bytes
    begin
      int d0;
      d0 = dec_cnt;
      @(negedge clk);
      vld = 1'b1; sof = 1'b1; eof = 1'b0; bt = 8'h77;
      @(negedge clk);
      check(acc == 1'b0 && miss == 1'b0, "R9 sof clears", int'({acc, miss}), 0);
      sof = 1'b0; bt = 8'h88;
      @(negedge clk);
      // restart with the station address
      for (int i = 0; i < 6; i++) begin
        sof = (i == 0);
        eof = (i == 5);
        bt  = STN[47 - 8*i -: 8];
        @(negedge clk);
      end
      vld = 1'b0; sof = 1'b0; eof = 1'b0;
      @(negedge clk);
      check(dec_cnt - d0 == 1, "R8 restart decision count", dec_cnt - d0, 1);
      check(dec_miss == 1'b0 && dec_acc == 1'b1, "R8 restart result",
            int'({dec_acc, dec_miss}), 2);
    end

    // R8 done is a single-cycle pulse
    begin
      int w;
      w = 0;
      fork
        send(STN, 6);
        repeat (10) begin @(negedge clk); if (done) w++; end
      join
      check(w == 1, "R8 pulse width", w, 1);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule